// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block takes a 32-bit configuration word from a three-wire serial link (an enable line, a serial clock and a single data line) and turns it into parallel control fields for a radio transmitter. All three wires are sampled by a faster system clock through synchronisers. The edges of the serial clock are detected in the system-clock domain.

While the enable line is high, one data bit is captured on each rising serial-clock edge, most significant bit first. The held register changes only at the falling serial-clock edge of the 32nd bit. A strobe marks the falling edge of the second bit, which carries the band choice, and a second strobe marks the commit. After the commit, the data line is routed out as the modulation input and further serial-clock activity is ignored. A low enable line clears the partial sequence, so the next load must supply all 32 bits. The held word is kept until a later load completes.

Top module: `cfg_serial_loader`

## Requirements
- R1: Bits are taken on rising serial-clock edges while the enable line is high, and the first bit taken becomes bit 31 of the word.
- R2: The held fields change only on the falling serial-clock edge of the 32nd bit. After the 32nd rising edge and before that falling edge, the old fields remain on the outputs.
- R3: `part_stb` pulses once per sequence, for one system clock, after the falling edge of the second bit (word bit 30). It does not pulse before that edge.
- R4: Field layout of the word: bit 31 clock-only mode, bit 30 upper band select, bits 29:15 frequency word (LSB at 15), bits 14:7 FSK separation (LSB at 7), bit 6 divide-by-4 clock select, bits 5:2 power level (LSB at 2), bit 1 ASK mode when high, bit 0 clock output enable.
- R5: Once 32 bits are loaded, more serial-clock pulses change neither the fields nor the bit count, and they produce no further commit strobe.
- R6: `mod_tx` is 0 until a load completes. After that, it follows the data line while the enable line stays high.
- R7: A low enable line clears the bit count, the shift register and the loaded state. The next commit then needs a fresh run of 32 bits.
- R8: A sequence cut short by a low enable line produces no commit strobe and leaves the held fields unchanged.
- R9: After reset, all fields, strobes, `prog_done` and `mod_tx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_en | input | 1 | Serial enable line |
| ser_dat | input | 1 | Serial data line; becomes the modulation input after a load |
| ser_clk | input | 1 | Serial clock |
| clk_only_mode | output | 1 | Word bit 31 |
| band_upper | output | 1 | Word bit 30 |
| freq_word | output | 15 | Word bits 29:15 |
| fsk_sep | output | 8 | Word bits 14:7 |
| clkdiv4_sel | output | 1 | Word bit 6 |
| pa_level | output | 4 | Word bits 5:2 |
| ask_mode | output | 1 | Word bit 1 |
| clkout_enable | output | 1 | Word bit 0 |
| part_stb | output | 1 | One-cycle pulse after the band bit's falling edge |
| prog_stb | output | 1 | One-cycle pulse at the same time as the fields update |
| prog_done | output | 1 | High while a completed load stands and the enable line stays high |
| mod_tx | output | 1 | Modulation output |

## Verification
The assertions check four properties on every cycle. The held word changes only after a commit request. The partial strobe appears only when two bits have been counted. The counter is frozen after a complete load and clears while the enable line is low. The modulation output stays silent before a load. The bench scenarios cover the rest: the bit order and field positions, the timing of the commit at the falling edge rather than the rising one, the fields surviving an aborted sequence, and a fresh sequence being required after the enable line drops.

// File: rtl/cfgl_pkg.sv
// Shared constants and field type for the serial configuration loader.
// Assumes a 32-bit word sent MSB first; the packed struct order matches
// the word's bit order, so a cast splits it into fields.
package cfgl_pkg;
    localparam int CFG_W    = 32;
    localparam int FREQ_W   = 15;
    localparam int FSEP_W   = 8;
    localparam int PWR_W    = 4;
    localparam int BAND_POS = 30;
    // bits received once the band bit is in
    localparam int PART_CNT = CFG_W - BAND_POS;

    typedef struct packed {
        logic              clk_only;
        logic              band_hi;
        logic [FREQ_W-1:0] freq;
        logic [FSEP_W-1:0] fsep;
        logic              div4;
        logic [PWR_W-1:0]  pwr;
        logic              ask;
        logic              clk_en;
    } cfg_fields_t;

    function automatic cfg_fields_t split_word(input logic [CFG_W-1:0] w);
        return cfg_fields_t'(w);
    endfunction
endpackage

// File: rtl/cfgl_edge_sync.sv
// Synchronises N asynchronous inputs into the system clock domain and flags
// their rising and falling edges. Assumes each input stays stable for
// more than STAGES+1 system clocks between changes.
module cfgl_edge_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] pipe [STAGES+1];

    // shift each input through the synchroniser stages plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s <= STAGES; s++) pipe[s] <= '0;
        end else begin
            pipe[0] <= din;
            for (int s = 1; s <= STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    // edge flags from the last synchronised stage against its history
    always_comb begin
        lvl  = pipe[STAGES-1];
        rise = pipe[STAGES-1] & ~pipe[STAGES];
        fall = ~pipe[STAGES-1] & pipe[STAGES];
    end
endmodule

// File: rtl/cfgl_shift.sv
// Shift register and bit counter for the serial word. Bits are captured on
// serial-clock rises; the partial and commit requests are raised on serial-clock
// falls. Assumes synchronised inputs, and a rise and a fall never in the same cycle.
module cfgl_shift
    import cfgl_pkg::*;
#(
    parameter int W    = CFG_W,
    parameter int PART = PART_CNT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         dat,
    input  logic         sck_rise,
    input  logic         sck_fall,
    output logic [W-1:0] word,
    output logic         part_stb,
    output logic         commit_req,
    output logic         loaded,
    output logic         mod_tx
);
    localparam int CNT_W = $clog2(W + 1);

    logic [CNT_W-1:0] cnt;
    logic             full;

    // the word is complete once W bits have been counted
    always_comb full = (cnt == CNT_W'(W));

    // capture bits, count them, and raise the partial and commit requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word       <= '0;
            cnt        <= '0;
            part_stb   <= 1'b0;
            commit_req <= 1'b0;
            loaded     <= 1'b0;
            mod_tx     <= 1'b0;
        end else begin
            part_stb   <= 1'b0;
            commit_req <= 1'b0;
            mod_tx     <= loaded & dat;
            if (!en) begin
                word   <= '0;
                cnt    <= '0;
                loaded <= 1'b0;
            end else begin
                if (sck_rise && !full) begin
                    word <= {word[W-2:0], dat};
                    cnt  <= cnt + 1'b1;
                end
                if (sck_fall && cnt == CNT_W'(PART)) part_stb <= 1'b1;
                if (sck_fall && full && !loaded) begin
                    commit_req <= 1'b1;
                    loaded     <= 1'b1;
                end
            end
        end
    end

    // R3: the partial strobe only comes with exactly PART bits counted
    assert_part_at_band_R3: assert property (@(posedge clk) disable iff (!rst_n)
        part_stb |-> (cnt == CNT_W'(PART)));

    // R5: a completed load freezes the counter while enable stays high
    assert_frozen_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && en) |=> (cnt == $past(cnt)));

    // R6: no modulation before a load completes
    assert_mod_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded |=> !mod_tx);

    // R7: a low enable clears the counter
    assert_clear_on_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0 && !loaded));
endmodule

// File: rtl/cfgl_hold.sv
// Holding register for the committed word. It loads only on a commit request
// and emits a done strobe in the same cycle as the new value appears.
module cfgl_hold
    import cfgl_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit_req,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] cfg_q,
    output logic         done_stb
);
    // take the shifted word on commit, otherwise keep the previous one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            done_stb <= 1'b0;
        end else begin
            done_stb <= commit_req;
            if (commit_req) cfg_q <= word_in;
        end
    end

    // R2 / R8: the held word moves only in response to a commit request
    assert_hold_until_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> $past(commit_req));
endmodule

// File: rtl/cfg_serial_loader.sv
// Top of the serial configuration loader. It synchronises the three bus
// wires, shifts in a 32-bit word and commits it on the last falling
// serial-clock edge, then breaks the word into control fields. Assumes the
// system clock is many times faster than the serial clock.
module cfg_serial_loader
    import cfgl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en,
    input  logic              ser_dat,
    input  logic              ser_clk,
    output logic              clk_only_mode,
    output logic              band_upper,
    output logic [FREQ_W-1:0] freq_word,
    output logic [FSEP_W-1:0] fsk_sep,
    output logic              clkdiv4_sel,
    output logic [PWR_W-1:0]  pa_level,
    output logic              ask_mode,
    output logic              clkout_enable,
    output logic              part_stb,
    output logic              prog_stb,
    output logic              prog_done,
    output logic              mod_tx
);
    localparam int NWIRE = 3;

    logic [NWIRE-1:0] wires, w_lvl, w_rise, w_fall;
    logic [CFG_W-1:0] shift_word, held;
    logic             commit_req;
    cfg_fields_t      f;

    // bundle the wires: bit 2 enable, bit 1 data, bit 0 serial clock
    always_comb wires = {ser_en, ser_dat, ser_clk};

    cfgl_edge_sync #(.N(NWIRE), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (wires),
        .lvl  (w_lvl),
        .rise (w_rise),
        .fall (w_fall)
    );

    cfgl_shift #(.W(CFG_W), .PART(PART_CNT)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (w_lvl[2]),
        .dat       (w_lvl[1]),
        .sck_rise  (w_rise[0]),
        .sck_fall  (w_fall[0]),
        .word      (shift_word),
        .part_stb  (part_stb),
        .commit_req(commit_req),
        .loaded    (prog_done),
        .mod_tx    (mod_tx)
    );

    cfgl_hold #(.W(CFG_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_req(commit_req),
        .word_in   (shift_word),
        .cfg_q     (held),
        .done_stb  (prog_stb)
    );

    // split the held word into its named fields
    always_comb begin
        f             = split_word(held);
        clk_only_mode = f.clk_only;
        band_upper    = f.band_hi;
        freq_word     = f.freq;
        fsk_sep       = f.fsep;
        clkdiv4_sel   = f.div4;
        pa_level      = f.pwr;
        ask_mode      = f.ask;
        clkout_enable = f.clk_en;
    end
endmodule

// File: tb/tb_cfg_serial_loader.sv
`timescale 1ns/1ps
module tb_cfg_serial_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_en = 1'b0, ser_dat = 1'b0, ser_clk = 1'b0;
    logic        clk_only_mode, band_upper, clkdiv4_sel, ask_mode, clkout_enable;
    logic [14:0] freq_word;
    logic [7:0]  fsk_sep;
    logic [3:0]  pa_level;
    logic        part_stb, prog_stb, prog_done, mod_tx;

    int total = 0, bad = 0;
    int n_part = 0, n_prog = 0;
    bit finished = 0;
    localparam int HALF = 10;

    always #4 clk = ~clk;

    cfg_serial_loader dut (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_dat(ser_dat), .ser_clk(ser_clk),
        .clk_only_mode(clk_only_mode), .band_upper(band_upper), .freq_word(freq_word),
        .fsk_sep(fsk_sep), .clkdiv4_sel(clkdiv4_sel), .pa_level(pa_level),
        .ask_mode(ask_mode), .clkout_enable(clkout_enable), .part_stb(part_stb),
        .prog_stb(prog_stb), .prog_done(prog_done), .mod_tx(mod_tx)
    );

    // count strobe pulses
    always @(posedge clk) begin
        if (rst_n) begin
            if (part_stb) n_part++;
            if (prog_stb) n_prog++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] fields_now();
        return {clk_only_mode, band_upper, freq_word, fsk_sep, clkdiv4_sel, pa_level, ask_mode, clkout_enable};
    endfunction

    // R4: compare each field against its position in the expected word
    task automatic chk_fields(input logic [31:0] w, input string tag);
        chk(clk_only_mode == w[31], {tag, " R4 clk_only"}, 32'(clk_only_mode), 32'(w[31]));
        chk(band_upper == w[30], {tag, " R4 band"}, 32'(band_upper), 32'(w[30]));
        chk(freq_word == w[29:15], {tag, " R4 freq"}, 32'(freq_word), 32'(w[29:15]));
        chk(fsk_sep == w[14:7], {tag, " R4 fsep"}, 32'(fsk_sep), 32'(w[14:7]));
        chk(clkdiv4_sel == w[6], {tag, " R4 div"}, 32'(clkdiv4_sel), 32'(w[6]));
        chk(pa_level == w[5:2], {tag, " R4 pwr"}, 32'(pa_level), 32'(w[5:2]));
        chk(ask_mode == w[1], {tag, " R4 ask"}, 32'(ask_mode), 32'(w[1]));
        chk(clkout_enable == w[0], {tag, " R4 clken"}, 32'(clkout_enable), 32'(w[0]));
    endtask

    task automatic bit_rise(input logic b);
        ser_dat = b; tick(HALF);
        ser_clk = 1'b1; tick(HALF);
    endtask

    task automatic bit_fall();
        ser_clk = 1'b0; tick(HALF);
    endtask

    task automatic go_idle(input logic d);
        ser_clk = 1'b0; ser_en = 1'b0; ser_dat = d; tick(HALF);
    endtask

    // full load with checks around the band bit and the final bit
    task automatic load_word(input logic [31:0] w, input logic [31:0] prev, input string tag);
        int p0, c0;
        p0 = n_part; c0 = n_prog;
        ser_en = 1'b1; tick(HALF);
        for (int i = 31; i >= 1; i--) begin
            bit_rise(w[i]);
            if (i == 30) chk(n_part == p0, {tag, " R3 no strobe before fall"}, 32'(n_part - p0), 0);
            bit_fall();
            if (i == 31) chk(n_part == p0, {tag, " R3 no strobe after bit31"}, 32'(n_part - p0), 0);
            if (i == 30) chk(n_part == p0 + 1, {tag, " R3 strobe after band bit"}, 32'(n_part - p0), 1);
        end
        bit_rise(w[0]);
        chk(fields_now() == prev, {tag, " R2 held until last fall"}, fields_now(), prev);
        chk(prog_done == 1'b0 && n_prog == c0, {tag, " R2 no commit on rise"}, 32'(n_prog - c0), 0);
        bit_fall();
        chk(n_prog == c0 + 1 && prog_done, {tag, " R2 commit once"}, 32'(n_prog - c0), 1);
        chk(fields_now() == w, {tag, " R1 word order"}, fields_now(), w);
        chk(n_part == p0 + 1, {tag, " R3 single strobe"}, 32'(n_part - p0), 1);
        chk_fields(w, tag);
    endtask

    task automatic t_reset();
        chk(fields_now() == 0, "R9 fields", fields_now(), 0);
        chk(!part_stb && !prog_stb && !prog_done && !mod_tx, "R9 strobes",
            {28'd0, part_stb, prog_stb, prog_done, mod_tx}, 0);
    endtask

    task automatic t_after_load(input logic [31:0] w);
        int c0;
        c0 = n_prog;
        ser_dat = 1'b1; tick(8);
        chk(mod_tx == 1'b1, "R6 mod high", 32'(mod_tx), 1);
        ser_dat = 1'b0; tick(8);
        chk(mod_tx == 1'b0, "R6 mod low", 32'(mod_tx), 0);
        for (int k = 0; k < 5; k++) begin
            bit_rise(k[0]);
            bit_fall();
        end
        chk(fields_now() == w, "R5 fields after extra clocks", fields_now(), w);
        chk(n_prog == c0, "R5 no extra commit", 32'(n_prog - c0), 0);
    endtask

    task automatic t_abort(input logic [31:0] held, input logic [31:0] other);
        int c0;
        c0 = n_prog;
        go_idle(1'b0);
        chk(prog_done == 1'b0 && mod_tx == 1'b0, "R7 idle clears loaded", {30'd0, prog_done, mod_tx}, 0);
        ser_en = 1'b1; tick(HALF);
        for (int i = 31; i >= 12; i--) begin
            bit_rise(other[i]);
            bit_fall();
        end
        go_idle(1'b0);
        chk(n_prog == c0, "R8 no commit on abort", 32'(n_prog - c0), 0);
        chk(fields_now() == held, "R8 fields kept", fields_now(), held);
    endtask

    localparam logic [31:0] WA = {1'b0, 1'b1, 15'd3730, 8'd100, 1'b1, 4'd8, 1'b1, 1'b1};
    localparam logic [31:0] WB = {1'b1, 1'b0, 15'd14342, 8'd255, 1'b0, 4'd15, 1'b0, 1'b0};
    localparam logic [31:0] WC = 32'hFFFF_FFFF;
    localparam logic [31:0] WD = 32'h0000_0001;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog R9 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(3);
        t_reset();
        load_word(WA, 32'd0, "A");
        t_after_load(WA);
        t_abort(WA, WB);
        // R7: fresh full sequence after abort
        load_word(WB, WA, "B R7");
        // register-reset style idle: enable low, data high
        go_idle(1'b1);
        tick(HALF);
        ser_dat = 1'b0;
        load_word(WC, WB, "C");
        go_idle(1'b0);
        load_word(WD, WC, "D");
        go_idle(1'b0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule